// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block sits at the digital heart of a multiphase buck controller with two, three or four phases. It turns a master clock tick into staggered start-of-cycle events and produces logic-level PWM lines from them. When enabled, it first spends a short detection window of master ticks in which every PWM line stays low. During that window it samples two probe flags that report whether the phase-3 and phase-4 output pins are tied to ground. The result of that sample fixes how many phases take part.

Once running, the block hands successive master ticks to the active phases in a fixed rotation. Each active phase therefore restarts once every N ticks, where N is the detected phase count. A PWM line rises when its phase is started and falls when that phase's end-of-duty input arrives. Phases are independent, so their high times may overlap, and a phase that never sees end-of-duty stays high at full duty. A phase found grounded is held low for as long as the block stays enabled. Dropping the enable clears everything, and the next enable repeats the detection.

Top module: `mphase_seq`

## Requirements
- R1: While `rst` is high or `en` is low at a clock edge, every `pwm_out` bit and `phase_cnt` are 0 after that edge.
- R2: After enable, the first DET_TICKS cycles with `tick` high (default 2) form the detection window. Throughout it all four `pwm_out` bits stay 0 and `phase_cnt` reads 0.
- R3: The probe flags are sampled on the last tick of the window. With `probe3_low`=1, `phase_cnt` becomes 2 whatever `probe4_low` is. With only `probe4_low`=1 it becomes 3. With neither it becomes 4. The new value is visible after that edge.
- R4: After detection, the first tick starts phase 1 (`pwm_out[0]`). Each later tick starts the next phase in the order 1, 2, 3, 4, wrapping after the last active phase.
- R5: Each active phase is started exactly once every `phase_cnt` ticks, so its switching rate is the tick rate divided by the phase count.
- R6: Phases with an index at or above `phase_cnt` (bit 2 when the count is 2 or less, bit 3 when it is 3 or less) stay 0 for the whole enabled period.
- R7: A start on a tick edge sets that phase's `pwm_out` bit high after the edge. Sampling `duty_end[i]` high clears bit i after the edge. If the start and `duty_end` for the same phase come in the same cycle, the start takes precedence.
- R8: Several `pwm_out` bits may be high at once. A phase without `duty_end` stays high across its consecutive starts, giving 100% duty.
- R9: Lowering `en` while running clears `pwm_out` and `phase_cnt` at the next edge. A following enable runs a fresh detection that can reach a different count.
- R10: Changes on `probe3_low` and `probe4_low` outside the sampling tick have no effect on `phase_cnt` or on the rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| tick | input | 1 | One-cycle master clock tick |
| probe3_low | input | 1 | Phase-3 pin seen grounded |
| probe4_low | input | 1 | Phase-4 pin seen grounded |
| duty_end | input | 4 | Per-phase end-of-duty request |
| pwm_out | output | 4 | Logic-level PWM lines, bit 0 is phase 1 |
| phase_cnt | output | 3 | Detected active phase count, 0 until detection ends |

## Verification
The bench builds the block with the default detection length of two ticks. This puts every detection outcome within reach in a short run: four, three, two with both probes low, and two with only the phase-3 probe low. It also lets the bench disable the block and enable it again mid-run several times. Ticks arrive every cycle, in sparse patterns and in irregular patterns. This exercises rotation wrap-around at each count, the case where a start and an end-of-duty collide, and phases held at full duty.

// File: rtl/mphase_pkg.sv
package mphase_pkg;
  localparam int MAX_PH = 4;
  localparam int SLOT_W = $clog2(MAX_PH);
  localparam int CNT_W  = $clog2(MAX_PH + 1);

  // Grounded phase-3 pin collapses to two phases regardless of phase 4.
  function automatic logic [CNT_W-1:0] decode_phases(input logic p3_low,
                                                     input logic p4_low);
    if (p3_low)      return CNT_W'(2);
    else if (p4_low) return CNT_W'(3);
    else             return CNT_W'(MAX_PH);
  endfunction
endpackage

// File: rtl/mphase_detect.sv
module mphase_detect
  import mphase_pkg::*;
#(
  parameter int DET_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             probe3_low,
  input  logic             probe4_low,
  output logic             run,
  output logic [CNT_W-1:0] cnt
);
  localparam int DW = $clog2(DET_TICKS + 1);

  logic [DW-1:0] det_n;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run   <= 1'b0;
      cnt   <= '0;
      det_n <= '0;
    end else if (!run && tick) begin
      if (det_n == DW'(DET_TICKS - 1)) begin
        run <= 1'b1;
        cnt <= decode_phases(probe3_low, probe4_low);
      end else begin
        det_n <= det_n + 1'b1;
      end
    end
  end

  // R3
  cnt_legal_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt >= CNT_W'(2) && cnt <= CNT_W'(MAX_PH)));
  // R2
  cnt_zero_detect_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> (cnt == '0));
  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(cnt));
endmodule

// File: rtl/mphase_rotor.sv
module mphase_rotor
  import mphase_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  output logic [MAX_PH-1:0] start
);
  logic [SLOT_W-1:0] slot;
  logic              wrap;

  assign wrap = (slot == SLOT_W'(cnt - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || !run)  slot <= '0;
    else if (tick)    slot <= wrap ? '0 : slot + 1'b1;
  end

  for (genvar i = 0; i < MAX_PH; i++) begin : g_start
    assign start[i] = run && tick && (slot == SLOT_W'(i));
  end

  // R4
  start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start));
  // R5
  slot_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (CNT_W'(slot) < cnt));
endmodule

// File: rtl/mphase_pwm_cell.sv
module mphase_pwm_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic allow,
  input  logic start,
  input  logic stop,
  output logic pwm
);
  always_ff @(posedge clk) begin
    if (rst || !en || !allow) pwm <= 1'b0;
    else if (start)           pwm <= 1'b1;
    else if (stop)            pwm <= 1'b0;
  end

  // R7
  rise_chk: assert property (@(posedge clk) disable iff (rst)
    (en && allow && start) |=> pwm);
  // R7
  fall_chk: assert property (@(posedge clk) disable iff (rst)
    (en && allow && !start && stop) |=> !pwm);
  // R1
  off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm);
  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !allow |=> !pwm);
endmodule

// File: rtl/mphase_seq.sv
module mphase_seq
  import mphase_pkg::*;
#(
  parameter int DET_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        tick,
  input  logic        probe3_low,
  input  logic        probe4_low,
  input  logic [3:0]  duty_end,
  output logic [3:0]  pwm_out,
  output logic [2:0]  phase_cnt
);
  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [MAX_PH-1:0] start;

  mphase_detect #(.DET_TICKS(DET_TICKS)) u_detect (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .probe3_low(probe3_low), .probe4_low(probe4_low),
    .run(run), .cnt(cnt)
  );

  mphase_rotor u_rotor (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .cnt(cnt), .start(start)
  );

  for (genvar i = 0; i < MAX_PH; i++) begin : g_phase
    logic allow;
    assign allow = run && (CNT_W'(i) < cnt);
    mphase_pwm_cell u_cell (
      .clk(clk), .rst(rst), .en(en), .allow(allow),
      .start(start[i]), .stop(duty_end[i]), .pwm(pwm_out[i])
    );
  end

  assign phase_cnt = cnt;

  // R2
  detect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_out == 4'b0000));
  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase_cnt == 3'd0));
endmodule

// File: tb/mphase_seq_tb.sv
module mphase_seq_tb;
  logic       clk = 1'b0;
  logic       rst, en, tick, probe3_low, probe4_low;
  logic [3:0] duty_end;
  logic [3:0] pwm_out;
  logic [2:0] phase_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_run;
  int m_detn, m_cnt, m_slot;
  bit [3:0] m_pwm;

  always #10 clk = ~clk;

  mphase_seq u_dut (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .probe3_low(probe3_low), .probe4_low(probe4_low),
    .duty_end(duty_end), .pwm_out(pwm_out), .phase_cnt(phase_cnt)
  );

  task automatic model_edge();
    bit [3:0] np;
    if (rst || !en) begin
      m_run = 0; m_detn = 0; m_cnt = 0; m_slot = 0; m_pwm = '0;
      return;
    end
    np = m_pwm;
    if (m_run) begin
      for (int i = 0; i < 4; i++) begin
        if (i >= m_cnt)                    np[i] = 1'b0;
        else if (tick && m_slot == i)      np[i] = 1'b1;
        else if (duty_end[i])              np[i] = 1'b0;
      end
      if (tick) m_slot = (m_slot + 1) % m_cnt;
    end else begin
      np = '0;
      if (tick) begin
        if (m_detn == 1) begin
          m_run = 1; m_slot = 0;
          m_cnt = probe3_low ? 2 : (probe4_low ? 3 : 4);
        end else m_detn++;
      end
    end
    m_pwm = np;
  endtask

  task automatic check(string req, int act, int exp, string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit t, bit [3:0] de);
    tick = t; duty_end = de;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cur_req, pwm_out, m_pwm, "pwm_out");
    check(cur_req, phase_cnt, m_cnt, "phase_cnt");
  endtask

  task automatic run_mix(int n, int tick_every, int end_pct);
    for (int k = 0; k < n; k++) begin
      bit [3:0] de;
      for (int b = 0; b < 4; b++) de[b] = ($urandom % 100) < end_pct;
      step((tick_every == 0) ? ($urandom % 2) : (k % tick_every == 0), de);
    end
  endtask

  initial begin
    rst = 1; en = 0; tick = 0; probe3_low = 0; probe4_low = 0; duty_end = '0;
    step(0, 0); step(1, 4'hF);
    rst = 0;
    cur_req = "R1"; step(1, 0); step(1, 0);
    check("R1", pwm_out, 0, "pwm after reset");
    check("R1", phase_cnt, 0, "cnt after reset");

    // R2 / R3: four phases
    en = 1; cur_req = "R2";
    step(1, 0);
    check("R2", pwm_out, 0, "pwm in window");
    check("R2", phase_cnt, 0, "cnt in window");
    step(0, 0);
    step(1, 0);
    check("R3", phase_cnt, 4, "four-phase count");
    cur_req = "R4"; step(1, 0);
    check("R4", pwm_out, 4'b0001, "phase1 first");
    step(1, 0);
    check("R4", pwm_out, 4'b0011, "phase2 next");
    step(1, 0); step(1, 0);
    check("R8", pwm_out, 4'b1111, "all overlap");
    cur_req = "R8"; step(1, 0);
    check("R8", pwm_out, 4'b1111, "full duty held");
    cur_req = "R7"; step(1, 4'b0010);
    check("R7", pwm_out, 4'b1111, "start beats end");
    step(0, 4'b0100);
    check("R7", pwm_out, 4'b1011, "end clears");
    cur_req = "R5"; run_mix(60, 1, 30);
    cur_req = "R10";
    for (int k = 0; k < 20; k++) begin
      probe3_low = k[0]; probe4_low = k[1];
      step(k % 2 == 0, 4'b0001);
    end
    check("R10", phase_cnt, 4, "probes ignored");

    // R9: disable, three phases
    cur_req = "R9"; en = 0; probe3_low = 0; probe4_low = 1;
    step(1, 0);
    check("R9", pwm_out, 0, "pwm cleared");
    check("R9", phase_cnt, 0, "cnt cleared");
    en = 1; cur_req = "R3";
    step(1, 0); step(1, 0);
    check("R3", phase_cnt, 3, "three-phase count");
    cur_req = "R6"; run_mix(60, 3, 20);
    run_mix(60, 0, 40);

    // phase-3 grounded only
    en = 0; step(0, 0);
    probe3_low = 1; probe4_low = 0; en = 1; cur_req = "R3";
    step(1, 0); step(1, 0);
    check("R3", phase_cnt, 2, "p3-only two-phase");
    cur_req = "R6"; run_mix(50, 1, 25);
    check("R6", pwm_out[3:2], 0, "upper phases low");

    // both grounded
    en = 0; step(0, 0);
    probe3_low = 1; probe4_low = 1; en = 1; cur_req = "R3";
    step(1, 0); step(0, 0); step(1, 0);
    check("R3", phase_cnt, 2, "both-low two-phase");
    cur_req = "R5"; run_mix(80, 0, 15);

    // back to four after re-enable
    en = 0; step(0, 0);
    probe3_low = 0; probe4_low = 0; en = 1; cur_req = "R9";
    step(1, 0); step(1, 0);
    check("R9", phase_cnt, 4, "fresh detection");
    cur_req = "R4"; run_mix(80, 2, 35);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule